// File: doc/BRIEF.md
# SPI Paged Register Slave

This block is a serial slave that gives an external host byte-wide read and write access to an internal register space. The host frames each transfer with an active-low select. The first byte of every frame is a command byte: its top bit chooses the direction (1 = read, 0 = write) and its low seven bits give an offset inside a 128-byte window. The full register address is the page-select input placed above that offset. Data bytes follow the command byte. They are written to the register space, or in a read they carry register contents back to the host.

With the burst input set, each data byte moves the offset on by one, wrapping inside the current window. Many neighbouring registers can then be reached with a single command byte. With the burst input clear, a frame carries exactly one data byte. The ready output paces the host: it drops while a register fetch or a write strobe is in progress. It also stays low while a frame-error flag is set. That flag records that the select was released in the middle of a byte.

The serial clock, select and data lines are synchronised into the core clock. Data is sampled on the rising serial-clock edge, most significant bit first, and the outgoing bit changes on the falling edge (SPI mode 0). The FSM has these states: IDLE (select inactive), CMD (collecting the command byte), FETCH (read strobe issued), LOAD (fetched byte placed in the shifter), XFER (data byte slot open), STORE (write strobe issued) and DRAIN (single-byte frame finished; further bytes are ignored). The transitions are as follows. Select release takes any state to IDLE. IDLE goes to CMD when select is asserted. CMD goes to FETCH on a read command and to XFER on a write command. FETCH goes to LOAD, and LOAD goes to XFER. From XFER, a completed byte leads to STORE on a write, to FETCH on a burst read, and to DRAIN on a single read. STORE goes to XFER in a burst and to DRAIN otherwise.

Top module: `spi_page_slave`

## Requirements
- R1: The first complete byte after select goes low is the command byte. Bit 7 = 1 selects read and bit 7 = 0 selects write. Bits 6..0 are the starting offset.
- R2: Every register strobe presents reg_addr = {page_sel, offset}, where the offset is 7 bits.
- R3: In a write frame, each accepted data byte produces exactly one single-cycle reg_wr pulse carrying that byte on reg_wdata. reg_wr and reg_rd are never high together.
- R4: In a read frame, the byte the host shifts in during the slot after the command byte (or after the previous accepted data byte) equals the register at the address for that slot. It is sent MSB first and changes on falling serial-clock edges.
- R5: With incr_en high at the end of the command byte, the offset advances by one after each data byte and wraps from 127 to 0 without changing the page.
- R6: With incr_en low, only the first data byte of a frame is acted on. Later bytes in that frame cause no write and no fetch.
- R7: spi_rdy is low while a fetch is pending (the reg_rd cycle and the cycle after it) and during the reg_wr cycle. Otherwise it is high while no error is flagged.
- R8: If select is released while a byte is partly shifted, the partial byte is discarded and no write is issued. frame_err rises and spi_rdy stays low until select is asserted again, and that assertion clears frame_err.
- R9: After reset, spi_rdy is 1, frame_err is 0, spi_miso is 0 and neither strobe is active.
- R10: Releasing select at a byte boundary ends the frame without error, and the next frame starts again with a command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from host, idle low |
| spi_ss_n | input | 1 | Active-low slave select |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| spi_rdy | output | 1 | High when the next byte may be shifted |
| frame_err | output | 1 | Set by a select release inside a byte |
| incr_en | input | 1 | Burst (auto-increment) enable, sampled per frame |
| page_sel | input | PAGE_W | Page number forming the upper address bits |
| reg_addr | output | PAGE_W+7 | Register address for the strobes |
| reg_rd | output | 1 | Single-cycle fetch strobe |
| reg_wr | output | 1 | Single-cycle write strobe |
| reg_wdata | output | 8 | Write data |
| reg_rdata | input | 8 | Fetched data, valid the cycle after reg_rd |

## Verification
The hardest state to reach is the partial-byte abort. The host must release select after some bits of a data byte have been sampled but before the eighth. The bench reaches it with a directed frame that shifts three bits of a write byte and then lifts select. It then confirms at the ports that no write strobe appeared, that the flag and ready behave as required, and that the next frame clears the flag. The wrap of the burst offset at the top of a page is reached by a directed burst that starts at offset 126. Random frames cover the mix of directions, lengths, pages and burst settings.

// File: rtl/spi_pg_pkg.sv
package spi_pg_pkg;
    localparam int BYTE_W = 8;
    localparam int OFS_W  = 7;
    localparam int CNT_W  = $clog2(BYTE_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_FETCH,
        ST_LOAD,
        ST_XFER,
        ST_STORE,
        ST_DRAIN
    } pg_state_t;
endpackage

// File: rtl/spi_pg_sync.sv
module spi_pg_sync #(
    parameter int         W      = 1,
    parameter int         STAGES = 2,
    parameter logic [W-1:0] RST  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES*W-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST}};
        else        chain <= {chain[(STAGES-1)*W-1:0], d};
    end

    assign q = chain[STAGES*W-1 -: W];
endmodule

// File: rtl/spi_pg_shift.sv
module spi_pg_shift
    import spi_pg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act,
    input  logic              sclk_s,
    input  logic              mosi_s,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_byte,
    output logic              byte_done,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              abort,
    output logic              miso
);
    logic              sclk_d;
    logic              act_d;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] rx_sr;
    logic [BYTE_W-1:0] tx_sr;
    logic              rise;
    logic              fall;

    assign rise      = sclk_s & ~sclk_d;
    assign fall      = ~sclk_s & sclk_d;
    assign byte_done = act & rise & (cnt == CNT_W'(BYTE_W-1));
    assign rx_byte   = {rx_sr[BYTE_W-2:0], mosi_s};
    assign abort     = act_d & ~act & (cnt != '0);
    assign miso      = tx_sr[BYTE_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            act_d  <= 1'b0;
            cnt    <= '0;
            rx_sr  <= '0;
            tx_sr  <= '0;
        end else begin
            sclk_d <= sclk_s;
            act_d  <= act;
            if (!act) begin
                cnt   <= '0;
                tx_sr <= '0;
            end else begin
                if (rise) begin
                    cnt   <= cnt + CNT_W'(1);
                    rx_sr <= rx_byte;
                end
                if (load)
                    tx_sr <= load_byte;
                else if (fall && cnt != '0)
                    tx_sr <= {tx_sr[BYTE_W-2:0], 1'b0};
            end
        end
    end
endmodule

// File: rtl/spi_pg_ctrl.sv
module spi_pg_ctrl
    import spi_pg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act,
    input  logic              byte_done,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              abort,
    input  logic              incr_en,
    output logic [OFS_W-1:0]  offset,
    output logic [BYTE_W-1:0] wdata,
    output logic              rd_stb,
    output logic              wr_stb,
    output logic              load,
    output logic              rdy,
    output logic              err
);
    pg_state_t state, nxt;
    logic      is_rd;
    logic      burst;

    always_comb begin
        nxt = state;
        if (!act) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  nxt = ST_CMD;
                ST_CMD:   if (byte_done) nxt = rx_byte[BYTE_W-1] ? ST_FETCH : ST_XFER;
                ST_FETCH: nxt = ST_LOAD;
                ST_LOAD:  nxt = ST_XFER;
                ST_XFER:  if (byte_done) begin
                              if (!is_rd)     nxt = ST_STORE;
                              else if (burst) nxt = ST_FETCH;
                              else            nxt = ST_DRAIN;
                          end
                ST_STORE: nxt = burst ? ST_XFER : ST_DRAIN;
                ST_DRAIN: nxt = ST_DRAIN;
                default:  nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            is_rd  <= 1'b0;
            burst  <= 1'b0;
            offset <= '0;
            wdata  <= '0;
            err    <= 1'b0;
        end else begin
            if (abort)
                err <= 1'b1;
            else if (state == ST_IDLE && act)
                err <= 1'b0;

            if (state == ST_CMD && byte_done) begin
                is_rd  <= rx_byte[BYTE_W-1];
                offset <= rx_byte[OFS_W-1:0];
                burst  <= incr_en;
            end
            if (state == ST_XFER && byte_done) begin
                wdata <= rx_byte;
                if (is_rd && burst) offset <= offset + OFS_W'(1);
            end
            if (state == ST_STORE && burst)
                offset <= offset + OFS_W'(1);
        end
    end

    always_comb begin
        rd_stb = (state == ST_FETCH);
        wr_stb = (state == ST_STORE);
        load   = (state == ST_LOAD);
        rdy    = !err && (state == ST_IDLE || state == ST_CMD ||
                          state == ST_XFER || state == ST_DRAIN);
    end
endmodule

// File: rtl/spi_page_slave.sv
module spi_page_slave
    import spi_pg_pkg::*;
#(
    parameter int PAGE_W      = 3,
    parameter int SYNC_STAGES = 2,
    localparam int ADDR_W     = PAGE_W + OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_ss_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_rdy,
    output logic              frame_err,
    input  logic              incr_en,
    input  logic [PAGE_W-1:0] page_sel,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_rd,
    output logic              reg_wr,
    output logic [BYTE_W-1:0] reg_wdata,
    input  logic [BYTE_W-1:0] reg_rdata
);
    logic [2:0]        pins_s;
    logic              act;
    logic              byte_done;
    logic [BYTE_W-1:0] rx_byte;
    logic              abort;
    logic              load;
    logic [OFS_W-1:0]  offset;

    spi_pg_sync #(.W(3), .STAGES(SYNC_STAGES), .RST(3'b010)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({spi_sclk, spi_ss_n, spi_mosi}),
        .q     (pins_s)
    );

    assign act = ~pins_s[1];

    spi_pg_shift u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .act       (act),
        .sclk_s    (pins_s[2]),
        .mosi_s    (pins_s[0]),
        .load      (load),
        .load_byte (reg_rdata),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .abort     (abort),
        .miso      (spi_miso)
    );

    spi_pg_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .act       (act),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .abort     (abort),
        .incr_en   (incr_en),
        .offset    (offset),
        .wdata     (reg_wdata),
        .rd_stb    (reg_rd),
        .wr_stb    (reg_wr),
        .load      (load),
        .rdy       (spi_rdy),
        .err       (frame_err)
    );

    assign reg_addr = {page_sel, offset};
endmodule

// File: rtl/spi_page_slave_chk.sv
module spi_page_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic spi_rdy,
    input logic frame_err,
    input logic reg_rd,
    input logic reg_wr
);
    assert_fetch_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |-> !spi_rdy);
    assert_load_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> !spi_rdy);
    assert_store_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> !spi_rdy);
    assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rd && reg_wr));
    assert_single_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr);
    assert_err_not_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> !spi_rdy);
    assert_err_no_access_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> !(reg_wr || reg_rd));
endmodule

bind spi_page_slave spi_page_slave_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .spi_rdy   (spi_rdy),
    .frame_err (frame_err),
    .reg_rd    (reg_rd),
    .reg_wr    (reg_wr)
);

// File: tb/tb_spi_page_slave.sv
`timescale 1ns/1ps
module tb_spi_page_slave;
    localparam int PAGE_W = 3;
    localparam int ADDR_W = PAGE_W + 7;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int HALF   = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              spi_sclk = 1'b0;
    logic              spi_ss_n = 1'b1;
    logic              spi_mosi = 1'b0;
    logic              spi_miso;
    logic              spi_rdy;
    logic              frame_err;
    logic              incr_en = 1'b0;
    logic [PAGE_W-1:0] page_sel = '0;
    logic [ADDR_W-1:0] reg_addr;
    logic              reg_rd;
    logic              reg_wr;
    logic [7:0]        reg_wdata;
    logic [7:0]        rdata_q;

    logic [7:0] mem [DEPTH];
    logic [7:0] expm [DEPTH];
    int         wr_cnt = 0;
    int         total = 0;
    int         bad = 0;

    always #2 clk = ~clk;

    spi_page_slave #(.PAGE_W(PAGE_W)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .spi_sclk  (spi_sclk),
        .spi_ss_n  (spi_ss_n),
        .spi_mosi  (spi_mosi),
        .spi_miso  (spi_miso),
        .spi_rdy   (spi_rdy),
        .frame_err (frame_err),
        .incr_en   (incr_en),
        .page_sel  (page_sel),
        .reg_addr  (reg_addr),
        .reg_rd    (reg_rd),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (rdata_q)
    );

    // register space model seen by the block
    always @(posedge clk) begin
        if (reg_wr) begin
            mem[reg_addr] <= reg_wdata;
            wr_cnt <= wr_cnt + 1;
        end
        if (reg_rd) rdata_q <= mem[reg_addr];
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int mem_diffs();
        int n = 0;
        for (int i = 0; i < DEPTH; i++) if (mem[i] !== expm[i]) n++;
        return n;
    endfunction

    function automatic logic [ADDR_W-1:0] slot_addr(input logic [PAGE_W-1:0] pg,
                                                    input logic [6:0] off, input int k);
        logic [6:0] o = off + 7'(k);
        return {pg, o};
    endfunction

    task automatic spi_byte(input logic [7:0] b, input bit busy, output logic [7:0] r);
        int t = 0;
        while (!spi_rdy && t < 200) begin @(negedge clk); t++; end
        if (t >= 200) chk("R7 ready timeout", 0, 1);
        for (int i = 7; i >= 0; i--) begin
            spi_mosi = b[i];
            repeat (HALF) @(negedge clk);
            r[i] = spi_miso;
            spi_sclk = 1'b1;
            if (i == 0) begin
                repeat (3) @(negedge clk);
                chk("R7 ready after byte", int'(spi_rdy), int'(!busy));
                repeat (HALF-3) @(negedge clk);
            end else begin
                repeat (HALF) @(negedge clk);
            end
            spi_sclk = 1'b0;
        end
    endtask

    task automatic frame(input bit rd, input logic [6:0] off, input int n, input bit inc,
                         input logic [PAGE_W-1:0] pg, input logic [63:0] dat);
        logic [7:0] rxb;
        int w0 = wr_cnt;
        page_sel = pg;
        incr_en  = inc;
        spi_ss_n = 1'b0;
        repeat (4) @(negedge clk);
        spi_byte({rd, off}, rd, rxb);                    // R1 command byte
        for (int k = 0; k < n; k++) begin
            bit busy = inc ? 1'b1 : (k == 0 ? !rd : 1'b0);
            spi_byte(rd ? 8'h00 : dat[k*8 +: 8], busy, rxb);
            if (inc || k == 0) begin
                if (rd) chk("R4 R2 read data", int'(rxb), int'(expm[slot_addr(pg, off, k)]));
                else    expm[slot_addr(pg, off, k)] = dat[k*8 +: 8];
            end
        end
        spi_ss_n = 1'b1;
        repeat (8) @(negedge clk);
        chk("R10 no error at byte boundary", int'(frame_err), 0);
        if (!rd) begin
            chk("R3 R6 write count", wr_cnt - w0, inc ? n : (n > 0 ? 1 : 0));
            chk("R2 R5 memory image", mem_diffs(), 0);
        end
    endtask

    initial begin
        logic [7:0] rxb;
        int w0;
        void'($urandom(32'd2024));
        for (int i = 0; i < DEPTH; i++) begin
            mem[i]  = 8'(i) ^ 8'h5A;
            expm[i] = 8'(i) ^ 8'h5A;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 reset ready", int'(spi_rdy), 1);
        chk("R9 reset err", int'(frame_err), 0);
        chk("R9 reset miso", int'(spi_miso), 0);
        chk("R9 reset strobes", int'({reg_rd, reg_wr}), 0);

        // R5 burst wrap inside page
        frame(1'b0, 7'd126, 4, 1'b1, 3'd5, 64'h0000_0000_D4C3_B2A1);
        frame(1'b1, 7'd126, 4, 1'b1, 3'd5, 64'h0);
        // R6 single-byte frames ignore extra bytes
        frame(1'b0, 7'd10, 3, 1'b0, 3'd2, 64'h0000_0000_0077_6655);
        frame(1'b1, 7'd10, 3, 1'b0, 3'd2, 64'h0);
        frame(1'b1, 7'd11, 1, 1'b0, 3'd2, 64'h0);
        // R10 frame with command only, then a normal read
        frame(1'b0, 7'd20, 0, 1'b1, 3'd1, 64'h0);
        frame(1'b1, 7'd20, 2, 1'b1, 3'd1, 64'h0);

        // R8 abort inside a data byte
        w0 = wr_cnt;
        page_sel = 3'd3; incr_en = 1'b1;
        spi_ss_n = 1'b0;
        repeat (4) @(negedge clk);
        spi_byte(8'h05, 1'b0, rxb);
        for (int i = 0; i < 3; i++) begin
            spi_mosi = 1'b1;
            repeat (HALF) @(negedge clk);
            spi_sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            spi_sclk = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        spi_ss_n = 1'b1;
        repeat (6) @(negedge clk);
        chk("R8 err set", int'(frame_err), 1);
        chk("R8 ready low", int'(spi_rdy), 0);
        chk("R8 no write", wr_cnt - w0, 0);
        chk("R8 memory untouched", mem_diffs(), 0);
        spi_ss_n = 1'b0;
        repeat (4) @(negedge clk);
        chk("R8 err cleared", int'(frame_err), 0);
        chk("R8 ready back", int'(spi_rdy), 1);
        spi_ss_n = 1'b1;
        repeat (8) @(negedge clk);

        // random frames
        for (int f = 0; f < 40; f++) begin
            bit         rd  = 1'($urandom % 2);
            logic [6:0] off = 7'($urandom);
            int         n   = 1 + int'($urandom % 4);
            bit         inc = 1'($urandom % 2);
            logic [PAGE_W-1:0] pg = PAGE_W'($urandom);
            logic [63:0] dat = {$urandom, $urandom};
            frame(rd, off, n, inc, pg, dat);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule